// File: doc/BRIEF.md
# Serial Memory Access Slave Port

This block is a serial-peripheral slave that gives an external host direct access to an on-chip data RAM. It can also pass a command byte to the local processor. The host frames each transaction with an active-low chip select. It then clocks in an 8-bit command, a 16-bit address sent most significant byte first, and any number of data bytes. Clock and data follow mode 0: data is sampled on the rising edge and changed on the falling edge, most significant bit first.

All pins are oversampled in the system clock domain through two-flop synchronisers. Command bit 7 set means a RAM transfer. Within a RAM transfer, command bit 0 picks a read (1) or a write (0). The block drives a synchronous single-port RAM interface. For a RAM read request, data returns on `ram_rdata` in the cycle after the RAM samples the request.

Every completed command byte is kept in `last_cmd`. Every completed address is kept in `last_addr`. A command with bit 7 clear raises a one-cycle `cmd_irq` so the processor can act on it. The `port_en` input switches the port off when its pins serve another function.

Top module: `spi_ram_port`

## Requirements
- R1: While chip select is high or `port_en` is low, `spi_miso_oe` is low (output in high impedance). Clock and data-in transitions change no output and no stored state.
- R2: With `port_en` low, a complete write transaction on the pins issues no RAM request and leaves `last_cmd`, `last_addr` and `cmd_irq` unchanged.
- R3: A transaction is framed as one command byte, then two address bytes (high byte first), then data bytes. Every byte is sent most significant bit first and sampled on the rising serial clock edge.
- R4: A command with bit 7 = 1 and bit 0 = 0 writes each data byte to the RAM. The first byte goes to the received address, and the address increments by one after each byte, carrying across byte boundaries (0x00FF to 0x0100).
- R5: A command with bit 7 = 1 and bit 0 = 1 returns RAM bytes on `spi_miso`, starting at the received address and incrementing after each byte. Output bits change after falling edges. Bit 7 of the first data byte is valid at the first rising edge after the address.
- R6: `last_cmd` takes each fully received command byte. `last_addr` is updated only when all 16 address bits of a transaction have arrived.
- R7: A command with bit 7 = 0 produces exactly one single-cycle `cmd_irq` pulse when the command byte completes. That transaction causes no RAM access, even if address and data bytes follow. A RAM command raises no pulse.
- R8: Raising chip select at any bit ends the transaction. A partial command byte is discarded, and the next transaction starts again with a command byte.
- R9: After reset, `spi_miso_oe`, `ram_req`, `cmd_irq`, `last_cmd` and `last_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Enables the serial port |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_clk | input | 1 | Serial clock from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (low = high impedance) |
| ram_req | output | 1 | RAM access strobe, one cycle |
| ram_we | output | 1 | RAM write when set with `ram_req` |
| ram_addr | output | 16 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid the cycle after the RAM samples a read |
| last_cmd | output | 8 | Most recent complete command byte |
| last_addr | output | 16 | Most recent complete address |
| cmd_irq | output | 1 | Processor command pulse |

## Verification
Every pin goes through two synchroniser flops and one edge register. So a write strobe, a `cmd_irq` pulse and an update of `last_cmd` or `last_addr` appear on the third system clock edge after the rising serial clock that completes the byte. A new `spi_miso` bit appears three edges after a falling serial clock. The bench holds each serial clock phase for eight system cycles and samples `spi_miso` on its own rising edges, as a host would, so every read bit has settled for at least four cycles. RAM writes and interrupts are observed by monitor processes at falling system clock edges, whatever the exact cycle. The register values are compared only after chip select has been high for eight cycles, well past the three-cycle latency.

// File: rtl/spi_ram_pkg.sv
// Package: shared constants and command decode for the serial RAM port.
// Assumes commands are one byte; bit 7 marks a RAM transfer and bit 0 its direction.
package spi_ram_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } frame_phase_t;

    // True when the command addresses data RAM
    function automatic logic cmd_is_mem(input logic [BYTE_W-1:0] c);
        return c[7];
    endfunction

    // True when the command reads data RAM
    function automatic logic cmd_is_read(input logic [BYTE_W-1:0] c);
        return c[7] & c[0];
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Module: multi-bit level synchroniser for asynchronous pins.
// Each bit passes STAGES flops; RESET_VAL gives the idle level per bit.
// Assumes the pins are slow relative to clk and each level lasts at least two clocks.
module spi_pin_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Purpose: first capture of the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= pin_async;
            end
        end else begin : g_next
            // Purpose: further settling stages
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/spi_rx_deser.sv
// Module: receive deserialiser. Shifts one bit per sample strobe, MSB first,
// and flags the bit that completes a byte with the assembled byte value.
// Assumes clear is held whenever the port is deselected.
module spi_rx_deser #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         sample,
    input  logic         din,
    output logic         byte_done,
    output logic [W-1:0] byte_val
);

    localparam int          CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] bit_cnt;
    logic [W-2:0]  shreg;

    // Purpose: count received bits and hold the partial byte
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (sample) begin
            shreg   <= {shreg[W-3:0], din};
            bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        end
    end

    assign byte_done = sample && (bit_cnt == LAST);
    assign byte_val  = {shreg, din};

    // R8: a deselect always leaves the bit counter at a byte boundary
    a_r8_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (bit_cnt == '0));

endmodule

// File: rtl/spi_tx_ser.sv
// Module: transmit serialiser. Loads a byte and presents one bit per shift
// strobe, MSB first, on a registered output.
// Assumes a load never falls in the same cycle as a shift strobe.
module spi_tx_ser #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         dout
);

    logic [W-1:0] shreg;

    // Purpose: hold the outgoing byte and step it out on each shift strobe
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg <= '0;
            dout  <= 1'b0;
        end else if (load) begin
            shreg <= load_val;
        end else if (shift) begin
            dout  <= shreg[W-1];
            shreg <= {shreg[W-2:0], 1'b0};
        end
    end

    // R5: output bit only moves on a shift strobe
    a_r5_dout_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !clear) |=> $stable(dout));

endmodule

// File: rtl/spi_frame_ctrl.sv
// Module: transaction framer. Walks command, address and data bytes,
// drives the RAM port, keeps the last command and address, and raises
// the processor command pulse.
// Assumes the RAM returns read data the cycle after it samples ram_req.
module spi_frame_ctrl
    import spi_ram_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int ADDR_W     = ADDR_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic [BYTE_W-1:0] ram_rdata,
    output logic              ram_req,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_wdata,
    output logic [BYTE_W-1:0] last_cmd,
    output logic [ADDR_W-1:0] last_addr,
    output logic              cmd_irq,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_val
);

    localparam int                IDX_W    = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(ADDR_BYTES - 1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    frame_phase_t      phase;
    logic [IDX_W-1:0]  addr_idx;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_next;
    logic [1:0]        rd_pipe;

    if (ADDR_W > BYTE_W) begin : g_wide
        // Purpose: append the received byte to the partial address
        always_comb addr_next = {addr_q[ADDR_W-BYTE_W-1:0], byte_val};
    end else begin : g_narrow
        // Purpose: single-byte address
        always_comb addr_next = byte_val;
    end

    // Purpose: frame state, RAM strobes, processor registers and read prefetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_CMD;
            addr_idx  <= '0;
            addr_q    <= '0;
            rd_pipe   <= '0;
            ram_req   <= 1'b0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
            last_cmd  <= '0;
            last_addr <= '0;
            cmd_irq   <= 1'b0;
            tx_load   <= 1'b0;
            tx_val    <= '0;
        end else begin
            ram_req <= 1'b0;
            ram_we  <= 1'b0;
            cmd_irq <= 1'b0;
            tx_load <= rd_pipe[1] & active;
            if (rd_pipe[1]) tx_val <= ram_rdata;
            rd_pipe <= {rd_pipe[0], 1'b0};
            if (!active) begin
                phase    <= PH_CMD;
                addr_idx <= '0;
                rd_pipe  <= '0;
            end else if (byte_done) begin
                case (phase)
                    PH_CMD: begin
                        last_cmd <= byte_val;
                        cmd_irq  <= !cmd_is_mem(byte_val);
                        addr_idx <= '0;
                        phase    <= PH_ADDR;
                    end
                    PH_ADDR: begin
                        addr_q <= addr_next;
                        if (addr_idx == IDX_LAST) begin
                            last_addr <= addr_next;
                            phase     <= PH_DATA;
                            if (cmd_is_read(last_cmd)) begin
                                ram_req  <= 1'b1;
                                ram_addr <= addr_next;
                                rd_pipe  <= 2'b01;
                            end
                        end else begin
                            addr_idx <= addr_idx + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (cmd_is_read(last_cmd)) begin
                            ram_req  <= 1'b1;
                            ram_addr <= addr_q + ADDR_ONE;
                            addr_q   <= addr_q + ADDR_ONE;
                            rd_pipe  <= 2'b01;
                        end else if (cmd_is_mem(last_cmd)) begin
                            ram_req   <= 1'b1;
                            ram_we    <= 1'b1;
                            ram_addr  <= addr_q;
                            ram_wdata <= byte_val;
                            addr_q    <= addr_q + ADDR_ONE;
                        end
                    end
                    default: phase <= PH_CMD;
                endcase
            end
        end
    end

    // R7: the command pulse lasts one cycle
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq |=> !cmd_irq);
    // R7: the command pulse never coincides with a RAM access
    a_r7_irq_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq |-> !ram_req);
    // R5: a read strobe is a single cycle
    a_r5_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && !ram_we) |=> !ram_req);
    // R6: stored address moves only when a byte completes
    a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_done |=> $stable(last_addr));
    // R2: no RAM activity while inactive
    a_r2_no_ram_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !ram_req);

endmodule

// File: rtl/spi_ram_port.sv
// Module: top of the serial RAM access slave. Synchronises the pins,
// detects serial clock edges and joins the deserialiser, serialiser and framer.
// Assumes each serial clock phase lasts at least four system clocks.
module spi_ram_port
    import spi_ram_pkg::*;
#(
    parameter int ADDR_BYTES  = 2,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = ADDR_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              spi_cs_n,
    input  logic              spi_clk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              ram_req,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_wdata,
    input  logic [BYTE_W-1:0] ram_rdata,
    output logic [BYTE_W-1:0] last_cmd,
    output logic [ADDR_W-1:0] last_addr,
    output logic              cmd_irq
);

    logic [2:0]        pins_sync;
    logic              cs_lvl, sclk_lvl, mosi_lvl, sclk_d;
    logic              sclk_rise, sclk_fall, active;
    logic              byte_done, tx_load;
    logic [BYTE_W-1:0] byte_val, tx_val;

    spi_pin_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b001)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async({spi_mosi, spi_clk, spi_cs_n}),
        .pin_sync (pins_sync)
    );

    assign cs_lvl   = pins_sync[0];
    assign sclk_lvl = pins_sync[1];
    assign mosi_lvl = pins_sync[2];
    assign active   = port_en & ~cs_lvl;

    // Purpose: previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_lvl;
    end

    assign sclk_rise = active & sclk_lvl & ~sclk_d;
    assign sclk_fall = active & ~sclk_lvl & sclk_d;

    // Purpose: drive the output only while selected and enabled
    always_ff @(posedge clk) begin
        if (!rst_n) spi_miso_oe <= 1'b0;
        else        spi_miso_oe <= active;
    end

    spi_rx_deser #(.W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!active),
        .sample   (sclk_rise),
        .din      (mosi_lvl),
        .byte_done(byte_done),
        .byte_val (byte_val)
    );

    spi_tx_ser #(.W(BYTE_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!active),
        .load    (tx_load),
        .load_val(tx_val),
        .shift   (sclk_fall),
        .dout    (spi_miso)
    );

    spi_frame_ctrl #(.ADDR_BYTES(ADDR_BYTES), .ADDR_W(ADDR_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .byte_done(byte_done),
        .byte_val (byte_val),
        .ram_rdata(ram_rdata),
        .ram_req  (ram_req),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .ram_wdata(ram_wdata),
        .last_cmd (last_cmd),
        .last_addr(last_addr),
        .cmd_irq  (cmd_irq),
        .tx_load  (tx_load),
        .tx_val   (tx_val)
    );

    // R1: deselected or disabled port releases the output next cycle
    a_r1_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl || !port_en) |=> !spi_miso_oe);
    // R2: disabled port issues no command pulse
    a_r2_no_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !cmd_irq);

endmodule

// File: tb/spi_ram_port_tb.sv
`timescale 1ns/1ps
module spi_ram_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_clk = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;
    logic        ram_req, ram_we, cmd_irq;
    logic [15:0] ram_addr, last_addr;
    logic [7:0]  ram_wdata, last_cmd;
    logic [7:0]  ram_rdata = 8'h00;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    int req_cnt = 0;
    bit oe_seen = 1'b0;
    logic [7:0]  mem [0:1023];
    logic [23:0] exp_wr [$];
    logic [7:0]  txb [0:15];
    logic [7:0]  rxb [0:15];

    always #2.5 clk = ~clk;

    spi_ram_port u_dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en),
        .spi_cs_n(spi_cs_n), .spi_clk(spi_clk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .last_cmd(last_cmd), .last_addr(last_addr), .cmd_irq(cmd_irq)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[9:8], 6'h15};
    endfunction

    // Synchronous RAM model
    always @(posedge clk) begin
        if (ram_req) begin
            if (ram_we) mem[ram_addr[9:0]] <= ram_wdata;
            else        ram_rdata <= mem[ram_addr[9:0]];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected writes (R4) and counts strobes
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_irq) irq_cnt++;
            if (spi_miso_oe) oe_seen = 1'b1;
            if (ram_req) begin
                req_cnt++;
                if (ram_we) begin
                    if (exp_wr.size() == 0) begin
                        chk("R4 unexpected write", {8'h0, ram_addr, ram_wdata}, 32'hFFFFFFFF);
                    end else begin
                        chk("R4 write addr/data", {8'h0, ram_addr, ram_wdata}, {8'h0, exp_wr.pop_front()});
                    end
                end
            end
        end
    end

    task automatic wcyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Send nbits of one byte MSB first, mode 0, capturing the returned bits
    task automatic sbits(input logic [7:0] b, input int nbits, output logic [7:0] r);
        r = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = b[i];
            wcyc(8);
            spi_clk = 1'b1;
            r[i] = spi_miso;
            wcyc(8);
            spi_clk = 1'b0;
        end
    endtask

    // Full transaction of n bytes from txb into rxb
    task automatic xfer(input int n);
        logic [7:0] r;
        spi_cs_n = 1'b0;
        wcyc(8);
        for (int k = 0; k < n; k++) begin
            sbits(txb[k], 8, r);
            rxb[k] = r;
        end
        wcyc(8);
        spi_cs_n = 1'b1;
        wcyc(8);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int irq0, req0;
        logic [7:0] r;
        for (int i = 0; i < 1024; i++) mem[i] = pat(16'(i));
        wcyc(4);
        rst_n = 1'b1;
        wcyc(3);
        // R9 reset values
        chk("R9 miso_oe", spi_miso_oe, 0);
        chk("R9 ram_req", ram_req, 0);
        chk("R9 cmd_irq", cmd_irq, 0);
        chk("R9 last_cmd", last_cmd, 0);
        chk("R9 last_addr", last_addr, 0);

        // R4 write burst, R3 framing
        port_en = 1'b1;
        exp_wr.push_back({16'h0010, 8'hA5});
        exp_wr.push_back({16'h0011, 8'h3C});
        exp_wr.push_back({16'h0012, 8'hF0});
        txb[0] = 8'h80; txb[1] = 8'h00; txb[2] = 8'h10;
        txb[3] = 8'hA5; txb[4] = 8'h3C; txb[5] = 8'hF0;
        xfer(6);
        chk("R4 all writes seen", exp_wr.size(), 0);
        chk("R6 last_cmd write", last_cmd, 8'h80);
        chk("R6 last_addr write", last_addr, 16'h0010);
        chk("R7 no irq for RAM cmd", irq_cnt, 0);
        chk("R1 oe during select", oe_seen, 1);

        // R5 read back written bytes
        txb[0] = 8'h81; txb[1] = 8'h00; txb[2] = 8'h10;
        txb[3] = 8'h00; txb[4] = 8'h00; txb[5] = 8'h00;
        xfer(6);
        chk("R5 read byte0", rxb[3], 8'hA5);
        chk("R5 read byte1", rxb[4], 8'h3C);
        chk("R5 read byte2", rxb[5], 8'hF0);

        // R5 read across 0x00FF -> 0x0100, R3 high address byte
        txb[0] = 8'h81; txb[1] = 8'h00; txb[2] = 8'hFE;
        xfer(7);
        for (int k = 0; k < 4; k++) chk("R5 read carry", rxb[3+k], pat(16'h00FE + 16'(k)));
        chk("R6 last_addr read", last_addr, 16'h00FE);

        // R4 write carry across byte boundary
        exp_wr.push_back({16'h01FF, 8'h11});
        exp_wr.push_back({16'h0200, 8'h22});
        txb[0] = 8'h80; txb[1] = 8'h01; txb[2] = 8'hFF;
        txb[3] = 8'h11; txb[4] = 8'h22;
        xfer(5);
        chk("R4 carry writes seen", exp_wr.size(), 0);

        // R7 command-only transaction
        irq0 = irq_cnt; req0 = req_cnt;
        txb[0] = 8'h42;
        xfer(1);
        chk("R7 irq once", irq_cnt - irq0, 1);
        chk("R6 last_cmd cmd-only", last_cmd, 8'h42);
        chk("R6 last_addr kept", last_addr, 16'h01FF);

        // R7 processor command with address and data: no RAM access
        irq0 = irq_cnt; req0 = req_cnt;
        txb[0] = 8'h15; txb[1] = 8'h12; txb[2] = 8'h34; txb[3] = 8'h99;
        xfer(4);
        chk("R7 irq with data", irq_cnt - irq0, 1);
        chk("R7 no RAM access", req_cnt - req0, 0);
        chk("R6 last_addr proc cmd", last_addr, 16'h1234);

        // R2 disabled port ignores a full write
        port_en = 1'b0;
        oe_seen = 1'b0;
        irq0 = irq_cnt; req0 = req_cnt;
        txb[0] = 8'h80; txb[1] = 8'h00; txb[2] = 8'h20; txb[3] = 8'h77;
        xfer(4);
        chk("R2 no RAM when off", req_cnt - req0, 0);
        chk("R2 last_cmd kept", last_cmd, 8'h15);
        chk("R2 last_addr kept", last_addr, 16'h1234);
        chk("R2 no irq when off", irq_cnt - irq0, 0);
        chk("R1 oe off when disabled", oe_seen, 0);

        // R1 clock and data toggling with chip select high
        port_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            spi_mosi = i[0];
            wcyc(8);
            spi_clk = ~spi_clk;
        end
        spi_clk = 1'b0;
        wcyc(8);
        chk("R1 no RAM while deselected", req_cnt - req0, 0);
        chk("R1 oe off while deselected", oe_seen, 0);
        chk("R1 last_cmd kept", last_cmd, 8'h15);

        // R8 abort inside a command byte
        spi_cs_n = 1'b0;
        wcyc(8);
        sbits(8'hC3, 5, r);
        wcyc(8);
        spi_cs_n = 1'b1;
        wcyc(8);
        chk("R8 partial cmd dropped", last_cmd, 8'h15);

        // R8 abort inside the address, then a fresh write
        spi_cs_n = 1'b0;
        wcyc(8);
        sbits(8'h80, 8, r);
        sbits(8'h03, 4, r);
        wcyc(8);
        spi_cs_n = 1'b1;
        wcyc(8);
        chk("R8 cmd before abort", last_cmd, 8'h80);
        chk("R8 addr not updated", last_addr, 16'h1234);
        exp_wr.push_back({16'h0030, 8'h5A});
        txb[0] = 8'h80; txb[1] = 8'h00; txb[2] = 8'h30; txb[3] = 8'h5A;
        xfer(4);
        chk("R8 restart write seen", exp_wr.size(), 0);
        chk("R8 restart addr", last_addr, 16'h0030);

        finish_run();
    end

endmodule